// File: doc/BRIEF.md
# Phase-One SPI Master with Hardware Slave Select

This block is a single-byte SPI master shift engine. A host loads a byte and pulses a start input. The block then produces eight serial bit times on SCK and MOSI, collects eight bits from MISO, and presents the received byte together with a one-cycle done pulse. Data changes on the first SCK edge of each bit and is captured on the second edge. The SCK idle level, the bit order and the SCK rate can all be set, and all of them are captured when the transfer starts.

When both the select-output enable and the fault-mode enable are set at start, the block also drives an active-low slave select. The select falls half an SCK period before the first clock edge and rises at the end of the eighth bit time. The block runs only one transfer at a time. Further start requests are dropped until the current transfer finishes.

Top module: `spi_cpha1_master`

## Requirements
- R1: After reset, sck=0, ss_n=1, mosi=0, busy=0, done=0 and rx_byte=0.
- R2: Every transfer produces exactly 16 SCK transitions. SCK rests at the cfg_cpol level before and after a transfer: 0 when cfg_cpol=0, 1 when cfg_cpol=1.
- R3: The spacing between consecutive SCK transitions is (cfg_div+1) system clocks.
- R4: MOSI changes only on odd-numbered SCK transitions (1st, 3rd, ...). When cfg_lsb_first=0, bit 7 of tx_byte is sent first and bit 0 last. When cfg_lsb_first=1, bit 0 is sent first and bit 7 last.
- R5: MISO is captured on even-numbered transitions. Received bits are placed into rx_byte with the same order rule, so bit significance is kept for either order.
- R6: When cfg_sel_oe=1 and cfg_fault_en=1 at start, ss_n falls (cfg_div+1) clocks before the first SCK transition and rises (cfg_div+1) clocks after the 16th, in the same cycle that done is high.
- R7: If cfg_sel_oe=0 or cfg_fault_en=0 at start, ss_n stays 1 for the whole transfer.
- R8: busy is high from the cycle after an accepted start until the cycle done pulses. done lasts one cycle per transfer. A start while busy is ignored.
- R9: After the last bit, MOSI keeps the value of the last bit sent until the next transfer launches.
- R10: tx_byte, cfg_cpol, cfg_lsb_first, cfg_div and the select enables are taken at start. Changing them during a transfer has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_lsb_first | input | 1 | 1: bit 0 first, 0: bit 7 first |
| cfg_sel_oe | input | 1 | Select-output enable |
| cfg_fault_en | input | 1 | Fault-mode enable, needed with cfg_sel_oe for ss_n |
| cfg_div | input | DIV_W | SCK half-period minus one, in system clocks |
| start | input | 1 | Start request, taken when idle |
| tx_byte | input | 8 | Byte to send |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at transfer end |
| rx_byte | output | 8 | Last received byte |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
The assertions check the cycle-level rules on every cycle: the single-cycle done pulse, busy falling together with done, ss_n low only while busy and only after an enabled start, ss_n rising only with done, MOSI moving only together with SCK, and the SCK idle level following cfg_cpol. The bench scenarios are needed for the rest. These are the exact count of 16 transitions, the (cfg_div+1) spacing and lead/tail windows, the bit order in both directions against a slave model, holding MOSI after the last bit, and the immunity to starts and configuration changes during a transfer.

// File: rtl/spi_cpha1_master.sv
module spi_cpha1_master #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_cpol,
  input  logic             cfg_lsb_first,
  input  logic             cfg_sel_oe,
  input  logic             cfg_fault_en,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             start,
  input  logic [7:0]       tx_byte,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rx_byte,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic             ss_n
);
  localparam int BITS  = 8;
  localparam int EDGES = 2 * BITS;
  localparam int EW    = $clog2(EDGES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_TAIL} st_t;

  st_t             st;
  logic [DIV_W-1:0] cnt, div_q;
  logic [EW-1:0]   edge_q;
  logic            pol_q, lsb_q, phase_q, mosi_q, ss_q, done_q;
  logic [7:0]      tx_q, rx_q, rx_out;

  logic       tick;
  logic [2:0] idx, pos;

  assign tick = (cnt == '0);
  assign idx  = 3'(edge_q >> 1);
  assign pos  = lsb_q ? idx : 3'(BITS - 1) - idx;

  assign busy    = (st != ST_IDLE);
  assign done    = done_q;
  assign rx_byte = rx_out;
  assign sck     = phase_q ^ pol_q;
  assign mosi    = mosi_q;
  assign ss_n    = ss_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      div_q   <= '0;
      edge_q  <= '0;
      pol_q   <= 1'b0;
      lsb_q   <= 1'b0;
      phase_q <= 1'b0;
      mosi_q  <= 1'b0;
      ss_q    <= 1'b1;
      done_q  <= 1'b0;
      tx_q    <= '0;
      rx_q    <= '0;
      rx_out  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          pol_q   <= cfg_cpol;
          phase_q <= 1'b0;
          if (start) begin
            tx_q   <= tx_byte;
            lsb_q  <= cfg_lsb_first;
            div_q  <= cfg_div;
            cnt    <= cfg_div;
            edge_q <= '0;
            ss_q   <= !(cfg_sel_oe && cfg_fault_en);
            st     <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (tick) begin
            phase_q <= !phase_q;
            cnt     <= div_q;
            edge_q  <= edge_q + 1'b1;
            if (!edge_q[0]) mosi_q <= tx_q[pos];
            else            rx_q[pos] <= miso;
            if (edge_q == EW'(EDGES - 1)) st <= ST_TAIL;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_TAIL: begin
          if (tick) begin
            ss_q   <= 1'b1;
            done_q <= 1'b1;
            rx_out <= rx_q;
            st     <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cpha1_master_chk.sv
module spi_cpha1_master_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic cfg_cpol,
  input logic cfg_sel_oe,
  input logic cfg_fault_en,
  input logic busy,
  input logic done,
  input logic sck,
  input logic mosi,
  input logic ss_n
);
  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r6_ss_low_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_n |-> busy);

  a_r6_ss_rise_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_n) |-> done);

  a_r7_ss_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ss_n) |-> $past(start && cfg_sel_oe && cfg_fault_en && !busy));

  a_r4_mosi_moves_with_sck: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> !$stable(sck));

  a_r2_sck_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $past(rst_n)) |-> (sck == $past(cfg_cpol)));
endmodule

bind spi_cpha1_master spi_cpha1_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cfg_cpol(cfg_cpol),
  .cfg_sel_oe(cfg_sel_oe), .cfg_fault_en(cfg_fault_en), .busy(busy),
  .done(done), .sck(sck), .mosi(mosi), .ss_n(ss_n)
);

// File: tb/test_spi_cpha1_master.sv
`timescale 1ns/1ps
module test_spi_cpha1_master;
  localparam int DIV_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_cpol = 0, cfg_lsb_first = 0, cfg_sel_oe = 0, cfg_fault_en = 0;
  logic [DIV_W-1:0] cfg_div = '0;
  logic start = 0;
  logic [7:0] tx_byte = '0;
  logic busy, done, sck, mosi, ss_n;
  logic [7:0] rx_byte;
  logic miso = 0;

  always #2 clk = ~clk;

  spi_cpha1_master #(.DIV_W(DIV_W)) i_spi_cpha1_master (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_lsb_first(cfg_lsb_first),
    .cfg_sel_oe(cfg_sel_oe), .cfg_fault_en(cfg_fault_en), .cfg_div(cfg_div),
    .start(start), .tx_byte(tx_byte), .busy(busy), .done(done), .rx_byte(rx_byte),
    .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  int checks = 0, failures = 0;
  logic [7:0] exp_rx[$];
  logic [7:0] exp_out[$];

  // slave model and measurement state
  logic [7:0] s_byte, s_got;
  logic s_lsb, prev_sck;
  int cyc = 0, edges, first_edge, last_edge, ss_fall, done_cyc, done_cnt;
  int min_gap, max_gap, mosi_moves_even;
  logic ss_low_seen, prev_ss, prev_mosi;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (sck !== prev_sck) begin
      edges++;
      if (edges == 1) first_edge = cyc;
      else begin
        if (cyc - last_edge < min_gap) min_gap = cyc - last_edge;
        if (cyc - last_edge > max_gap) max_gap = cyc - last_edge;
      end
      last_edge = cyc;
      if (edges % 2 == 1) miso = s_lsb ? s_byte[(edges-1)/2] : s_byte[7-(edges-1)/2];
      else begin
        if (s_lsb) s_got[edges/2-1] = mosi; else s_got[8-edges/2] = mosi;
      end
    end
    if (mosi !== prev_mosi && (edges % 2 == 0)) mosi_moves_even++;
    if (prev_ss === 1'b1 && ss_n === 1'b0) ss_fall = cyc;
    if (ss_n === 1'b0) ss_low_seen = 1'b1;
    prev_ss = ss_n; prev_sck = sck; prev_mosi = mosi;
    if (done === 1'b1) begin
      done_cyc = cyc;
      done_cnt++;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done === 1'b1) begin
      if (exp_rx.size() == 0) chk("R8 unexpected done", 1, 0);
      else begin
        chk("R5 rx_byte", rx_byte, exp_rx.pop_front());
        chk("R4 slave received", s_got, exp_out.pop_front());
      end
    end
  end

  task automatic xfer(logic [7:0] tx, logic [7:0] sb, logic pol, logic lsb,
                      int div, logic oe, logic fen, bit poke);
    int h = div + 1;
    @(posedge clk); #1;
    cfg_cpol = pol; cfg_lsb_first = lsb; cfg_div = DIV_W'(div);
    cfg_sel_oe = oe; cfg_fault_en = fen; tx_byte = tx;
    repeat (3) @(posedge clk);
    #1;
    chk("R2 idle sck level", sck, pol);
    edges = 0; min_gap = 1 << 30; max_gap = 0; ss_low_seen = 0; done_cnt = 0;
    mosi_moves_even = 0; ss_fall = -1;
    s_byte = sb; s_lsb = lsb; s_got = 8'h00;
    exp_rx.push_back(sb); exp_out.push_back(tx);
    start = 1;
    @(posedge clk); #1;
    start = 0;
    chk("R8 busy after start", busy, 1);
    if (poke) begin
      repeat (2 * h + 1) @(posedge clk);
      #1;
      start = 1; tx_byte = ~tx; cfg_cpol = ~pol; cfg_lsb_first = ~lsb;
      cfg_div = DIV_W'(div + 2); cfg_sel_oe = ~oe;
      @(posedge clk); #1;
      start = 0; tx_byte = tx; cfg_cpol = pol; cfg_lsb_first = lsb;
      cfg_div = DIV_W'(div); cfg_sel_oe = oe;
    end
    while (done_cnt == 0) @(negedge clk);
    @(negedge clk);
    chk("R8 done single pulse", done, 0);
    chk("R8 busy low after done", busy, 0);
    chk("R2 sixteen transitions", edges, 16);
    chk("R3 min spacing", min_gap, h);
    chk("R3 max spacing", max_gap, h);
    chk("R4 mosi steady on even edges", mosi_moves_even, 0);
    chk("R2 sck back idle", sck, pol);
    if (oe && fen) begin
      chk("R6 ss lead window", first_edge - ss_fall, h);
      chk("R6 ss tail window", done_cyc - last_edge, h);
      chk("R6 ss high at end", ss_n, 1);
    end else begin
      chk("R7 ss stays high", ss_low_seen, 0);
    end
    repeat (4) @(negedge clk);
    chk("R9 mosi holds last bit", mosi, lsb ? tx[7] : tx[0]);
    chk("R8 one done per transfer", done_cnt, 1);
    if (poke) chk("R10 config frozen, start ignored", edges, 16);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    prev_sck = 0; prev_ss = 1; prev_mosi = 0;
    edges = 0; done_cnt = 0; s_byte = 0; s_lsb = 0; s_got = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 sck", sck, 0);
    chk("R1 ss_n", ss_n, 1);
    chk("R1 mosi", mosi, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 rx_byte", rx_byte, 0);
    rst_n = 1;
    xfer(8'hA5, 8'h3C, 0, 0, 0, 1, 1, 0);
    xfer(8'h81, 8'hC3, 1, 0, 1, 1, 1, 0);
    xfer(8'h1E, 8'hB2, 0, 1, 3, 1, 1, 0);
    xfer(8'h7F, 8'h01, 1, 1, 0, 0, 1, 0);
    xfer(8'hFE, 8'h80, 0, 0, 2, 1, 0, 0);
    xfer(8'h5A, 8'hE7, 1, 0, 2, 1, 1, 1);
    xfer(8'h01, 8'h6D, 0, 1, 1, 1, 1, 1);
    repeat (5) @(posedge clk);
    chk("R8 scoreboard drained", exp_rx.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule